// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Generator

This block takes an oscillator clock running at one of three crystal rates and divides it to a common 32.768 kHz-equivalent tick. From that tick it produces a one-second pulse, a programmable periodic event and a square wave. One 4-bit rate code sets both the periodic event and the square wave. Software writes two control registers: one selects the time base and the rate, and the other holds four enable bits.

The periodic event, an external alarm event and an external update-ended event each set their own flag. The flags drive a single active-low interrupt line, and each source has its own enable. A status read returns the three flags together with a summary bit, and that read clears the flags in the same cycle.

Top module: `tick_irq_gen`

## Requirements
- R1: After reset the time-base code is 3 (divider held), the rate code is 0 and all enables are 0. While reset is active and on the first cycle after it, irq_n is 1, sqw_out and sec_tick are 0, and rd_data is 0.
- R2: The time-base code is written to bits [1:0] at address 0. The divider runs from the moment it is released. Code 0 (4.194304 MHz) gives one tick every 128 clocks. Code 1 (1.048576 MHz) gives one tick every 32 clocks. Code 2 (32.768 kHz) gives one tick every clock. Code 3 holds the whole divider at zero and produces no tick.
- R3: sec_tick is a one-clock pulse, registered one cycle after every 32768th tick.
- R4: The rate code is written to bits [7:4] at address 0. For codes 3 to 15 the periodic event repeats every 2^(code-1) ticks. With time-base codes 0 or 1, code 1 gives 1 tick and code 2 gives 2 ticks.
- R5: With time-base code 2, rate codes 1 and 2 behave like codes 8 and 9.
- R6: Rate code 0 produces no periodic event and holds sqw_out low.
- R7: The square wave has a period equal to the periodic period and toggles at each half-period. It starts low after the divider is released. It is registered one clock after the divider state, and it is driven only while the enable bit at address 1, bit 3, is set; otherwise it is 0.
- R8: A periodic event, an alarm_evt pulse or an update_evt pulse each set their own flag, whatever the enables. The flag is visible on the next clock.
- R9: The enables are written to address 1: bit 0 periodic, bit 1 alarm, bit 2 update. irq_n is 0 exactly when some flag and its enable are both 1, and rd_data bit 7 mirrors this condition.
- R10: rd_data shows the flags at bit 6 (periodic), bit 5 (alarm) and bit 4 (update), with bits [3:0] at 0. A clock with rd_flags high clears every flag, except that an event arriving in that same clock sets its flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock at the selected crystal rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_addr | input | 1 | 0: time base and rate, 1: enables |
| wr_data | input | 8 | Write data |
| rd_flags | input | 1 | Status read strobe; clears the flags |
| rd_data | output | 8 | Summary bit and the three flags |
| alarm_evt | input | 1 | Alarm match pulse from the calendar |
| update_evt | input | 1 | Update-ended pulse from the calendar |
| sec_tick | output | 1 | One-second pulse |
| sqw_out | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The divider is exercised under every time-base code with a fast rate code. Comparing the periodic and square-wave timing under these codes separates the 128, 32 and 1 clock prescales, and shows whether the half-tick square wave is taken from the correct prescaler bit. Under the 32.768 kHz base the bench runs the slowest rate long enough to reach a full second, then uses codes 1 and 2 to show the alias to codes 8 and 9, and code 0 to show that both outputs stop. Alarm and update pulses arrive at unrelated intervals, with several enable masks. Some of these pulses coincide with status reads, which separates a correct clear from one that loses an event.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int PRE_W   = 7;
  localparam int CHAIN_W = 15;
  localparam int NSRC    = 3;
  localparam int SRC_P   = 0;
  localparam int SRC_A   = 1;
  localparam int SRC_U   = 2;

  typedef enum logic [1:0] {
    TB_4M   = 2'd0,
    TB_1M   = 2'd1,
    TB_32K  = 2'd2,
    TB_HOLD = 2'd3
  } tbase_e;

  // Effective rate code after aliasing of the two fastest codes on the slow base.
  function automatic logic [3:0] eff_rate(tbase_e b, logic [3:0] s);
    if (b == TB_32K && (s == 4'd1 || s == 4'd2)) return s + 4'd7;
    return s;
  endfunction

  // Low chain bits that must all be ones on the tick that ends a period.
  function automatic logic [CHAIN_W-1:0] rate_mask(logic [3:0] e);
    logic [CHAIN_W-1:0] one;
    one = {{(CHAIN_W-1){1'b0}}, 1'b1};
    if (e == 4'd0) return '0;
    return (one << (e - 4'd1)) - one;
  endfunction
endpackage

// File: rtl/tb_prescaler.sv
module tb_prescaler
  import tick_irq_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  tbase_e base,
  output logic   tick32,
  output logic   half_bit
);
  localparam int SLOW_W = W - 2;

  logic [W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (base == TB_HOLD)  pre <= '0;
    else                       pre <= pre + 1'b1;
  end

  always_comb begin
    case (base)
      TB_4M:   begin tick32 = &pre;             half_bit = pre[W-1];      end
      TB_1M:   begin tick32 = &pre[SLOW_W-1:0]; half_bit = pre[SLOW_W-1]; end
      TB_32K:  begin tick32 = 1'b1;             half_bit = 1'b0;          end
      default: begin tick32 = 1'b0;             half_bit = 1'b0;          end
    endcase
  end
endmodule

// File: rtl/rate_chain.sv
module rate_chain
  import tick_irq_pkg::*;
#(
  parameter int W = CHAIN_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       tick32,
  input  logic       half_bit,
  input  logic [3:0] eff,
  output logic       p_evt,
  output logic       s_evt,
  output logic       sq_bit
);
  logic [W-1:0] chain;
  logic [W-1:0] mask;
  logic [3:0]   sq_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain <= '0;
    else if (hold)    chain <= '0;
    else if (tick32)  chain <= chain + 1'b1;
  end

  assign mask   = rate_mask(eff);
  assign p_evt  = tick32 && (eff != 4'd0) && ((chain & mask) == mask);
  assign s_evt  = tick32 && (&chain);
  assign sq_idx = eff - 4'd2;

  always_comb begin
    if (eff == 4'd0)      sq_bit = 1'b0;
    else if (eff == 4'd1) sq_bit = half_bit;
    else                  sq_bit = chain[sq_idx];
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_clr,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] en_vec,
  output logic [N-1:0] flags,
  output logic         irq_any
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (rd_clr) flags[i] <= set_vec[i];
      else             flags[i] <= flags[i] | set_vec[i];
    end
  end

  assign irq_any = |(flags & en_vec);
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
  import tick_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_flags,
  output logic [7:0] rd_data,
  input  logic       alarm_evt,
  input  logic       update_evt,
  output logic       sec_tick,
  output logic       sqw_out,
  output logic       irq_n
);
  tbase_e         base;
  logic [3:0]     rate_sel;
  logic [NSRC-1:0] src_en;
  logic           sqw_en;

  logic           hold, tick32, half_bit;
  logic [3:0]     eff;
  logic           p_evt, s_evt, sq_bit;
  logic [NSRC-1:0] set_vec, flags;
  logic           irq_any;
  logic           sqw_q, sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base     <= TB_HOLD;
      rate_sel <= '0;
      src_en   <= '0;
      sqw_en   <= 1'b0;
    end else if (wr_en) begin
      if (!wr_addr) begin
        base     <= tbase_e'(wr_data[1:0]);
        rate_sel <= wr_data[7:4];
      end else begin
        src_en <= wr_data[NSRC-1:0];
        sqw_en <= wr_data[3];
      end
    end
  end

  assign hold = (base == TB_HOLD);
  assign eff  = eff_rate(base, rate_sel);

  tb_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .base(base),
    .tick32(tick32), .half_bit(half_bit)
  );

  rate_chain #(.W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick32(tick32),
    .half_bit(half_bit), .eff(eff),
    .p_evt(p_evt), .s_evt(s_evt), .sq_bit(sq_bit)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[SRC_P] = p_evt;
    set_vec[SRC_A] = alarm_evt;
    set_vec[SRC_U] = update_evt;
  end

  irq_merge #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .rd_clr(rd_flags),
    .set_vec(set_vec), .en_vec(src_en),
    .flags(flags), .irq_any(irq_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sqw_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      sqw_q <= sqw_en && (rate_sel != 4'd0) && sq_bit;
      sec_q <= s_evt;
    end
  end

  assign sqw_out  = sqw_q;
  assign sec_tick = sec_q;
  assign irq_n    = ~irq_any;
  assign rd_data  = {irq_any, flags[SRC_P], flags[SRC_A], flags[SRC_U], 4'b0000};
endmodule

// File: rtl/tick_irq_gen_chk.sv
module tick_irq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_flags,
  input logic       alarm_evt,
  input logic       update_evt,
  input logic       sqw_out,
  input logic       sec_tick,
  input logic       irq_n,
  input logic [3:0] flg_view,
  input logic       p_evt,
  input logic       tick32,
  input logic       hold,
  input logic [3:0] rate_sel,
  input logic       sqw_en
);
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !tick32);
  assert_sec_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  assert_rate_off_sqw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !sqw_out);
  assert_rate_off_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |-> !p_evt);
  assert_sqw_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |=> !sqw_out);
  assert_pf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    p_evt |=> flg_view[2]);
  assert_af_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> flg_view[1]);
  assert_uf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |=> flg_view[0]);
  assert_irq_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n != flg_view[3]);
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !p_evt && !alarm_evt && !update_evt) |=> (irq_n && flg_view[2:0] == 3'b000));
endmodule

bind tick_irq_gen tick_irq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_flags(rd_flags), .alarm_evt(alarm_evt),
  .update_evt(update_evt), .sqw_out(sqw_out), .sec_tick(sec_tick),
  .irq_n(irq_n), .flg_view(rd_data[7:4]), .p_evt(p_evt), .tick32(tick32),
  .hold(hold), .rate_sel(rate_sel), .sqw_en(sqw_en)
);

// File: tb/tick_irq_gen_tb.sv
module tick_irq_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_flags = 1'b0;
  logic [7:0] rd_data;
  logic       alarm_evt = 1'b0;
  logic       update_evt = 1'b0;
  logic       sec_tick, sqw_out, irq_n;

  int vectors = 0;
  int fails   = 0;
  bit chk_on  = 1'b0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tick_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_flags(rd_flags), .rd_data(rd_data),
    .alarm_evt(alarm_evt), .update_evt(update_evt),
    .sec_tick(sec_tick), .sqw_out(sqw_out), .irq_n(irq_n)
  );

  // Behavioural reference: cycle and tick counts since the divider was released.
  int m_base = 3, m_rate = 0, m_en = 0;
  int m_raw = 0, m_ticks = 0;
  bit m_pf = 0, m_af = 0, m_uf = 0, m_sqw = 0, m_sec = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 3; m_rate = 0; m_en = 0; m_raw = 0; m_ticks = 0;
      m_pf = 0; m_af = 0; m_uf = 0; m_sqw = 0; m_sec = 0;
    end else begin
      int div, e, t, pev, sbit;
      div = (m_base == 0) ? 128 : (m_base == 1) ? 32 : 1;
      t = (m_base == 3) ? 0 : (((m_raw + 1) % div) == 0);
      e = (m_base == 2 && (m_rate == 1 || m_rate == 2)) ? m_rate + 7 : m_rate;
      pev = t && (e != 0) && (((m_ticks + 1) % (1 << (e - 1))) == 0);
      if (e == 0) sbit = 0;
      else if (e == 1) sbit = (m_raw / (div / 2)) % 2;
      else sbit = (m_ticks / (1 << (e - 2))) % 2;
      m_sqw = ((m_en & 8) != 0) && (m_rate != 0) && (sbit != 0);
      m_sec = t && (((m_ticks + 1) % 32768) == 0);
      if (rd_flags) begin
        m_pf = pev; m_af = alarm_evt; m_uf = update_evt;
      end else begin
        m_pf = m_pf | pev; m_af = m_af | alarm_evt; m_uf = m_uf | update_evt;
      end
      if (m_base == 3) begin m_raw = 0; m_ticks = 0; end
      else begin m_raw = m_raw + 1; m_ticks = m_ticks + t; end
      if (wr_en) begin
        if (!wr_addr) begin m_base = wr_data[1:0]; m_rate = wr_data[7:4]; end
        else m_en = wr_data[3:0];
      end
    end
  end

  function automatic bit m_irq();
    return (m_pf && (m_en & 1)) || (m_af && (m_en & 2)) || (m_uf && (m_en & 4));
  endfunction

  always @(negedge clk) begin
    if (chk_on && !done) begin
      logic [7:0] exp_rd;
      exp_rd = {m_irq(), m_pf, m_af, m_uf, 4'b0000};
      vectors++;
      if (sec_tick !== m_sec) begin
        fails++; $display("FAIL R3 sec_tick actual %b expected %b at %0t", sec_tick, m_sec, $time);
      end
      if (sqw_out !== m_sqw) begin
        fails++; $display("FAIL R7 sqw_out actual %b expected %b at %0t", sqw_out, m_sqw, $time);
      end
      if (irq_n !== !m_irq()) begin
        fails++; $display("FAIL R9 irq_n actual %b expected %b at %0t", irq_n, !m_irq(), $time);
      end
      if (rd_data !== exp_rd) begin
        fails++; $display("FAIL R10 rd_data actual %h expected %h at %0t", rd_data, exp_rd, $time);
      end
    end
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input int rd_every, input int al_every, input int up_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_flags   = (rd_every != 0) && (i % rd_every == rd_every - 1);
      alarm_evt  = (al_every != 0) && (i % al_every == 7);
      update_evt = (up_every != 0) && (i % up_every == 3);
    end
    @(negedge clk);
    rd_flags = 1'b0; alarm_evt = 1'b0; update_evt = 1'b0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs held at their reset values
    check("R1", {irq_n, sqw_out, sec_tick, 5'b0}, 8'h80);
    check("R1", rd_data, 8'h00);
    rst_n = 1'b1;
    chk_on = 1'b1;
    run(20, 0, 0, 0);
    check("R1", {irq_n, sqw_out, rd_data[7:4], 2'b0}, 8'h80);

    wr(1'b1, 8'h0F);
    // R2 R4: 32.768 kHz base, rate 3 (4 ticks)
    wr(1'b0, 8'h32);
    run(200, 37, 53, 71);
    // R3: slowest rate long enough for a second boundary
    wr(1'b0, 8'hF2);
    run(33000, 5000, 0, 0);
    // R2 R4: fastest base with rate 1 (half-tick square wave)
    wr(1'b0, 8'h03);
    wr(1'b0, 8'h10);
    run(1500, 301, 0, 0);
    // R2 R4: middle base with rate 2
    wr(1'b0, 8'h21);
    run(800, 97, 0, 0);
    // R5: aliasing of codes 1 and 2 on the slow base
    wr(1'b0, 8'h12);
    run(700, 250, 0, 0);
    wr(1'b0, 8'h22);
    run(1100, 250, 0, 0);
    // R6: rate 0 stops both outputs
    wr(1'b0, 8'h02);
    run(300, 40, 0, 0);
    // R7: square wave gated off
    wr(1'b1, 8'h07);
    wr(1'b0, 8'h32);
    run(200, 33, 0, 0);
    // R8 R9: all sources masked, flags still set
    wr(1'b1, 8'h00);
    run(60, 0, 30, 45);
    check("R9", {7'b0, irq_n}, 8'h01);
    check("R8", rd_data & 8'h30, 8'h30);
    wr(1'b1, 8'h02);
    @(negedge clk);
    check("R9", {7'b0, irq_n}, 8'h00);
    // R10: read coinciding with an alarm event keeps the alarm flag
    wr(1'b0, 8'h03);
    @(negedge clk);
    rd_flags = 1'b1; alarm_evt = 1'b1;
    @(negedge clk);
    rd_flags = 1'b0; alarm_evt = 1'b0;
    check("R10", rd_data, 8'hA0);
    @(negedge clk);
    rd_flags = 1'b1;
    @(negedge clk);
    rd_flags = 1'b0;
    check("R10", {rd_data[7:4], 3'b0, irq_n}, 8'h01);
    run(10, 0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule